// File: doc/BRIEF.md
# Latched Jump Vertical Motion Controller

This block drives the vertical coordinate of a square sprite in a side-scrolling game. A single tap of the jump button starts a complete jump. The tap is captured in a request register of its own, so the sprite rises at a fixed rate to an apex line and then falls back to the floor. The jump button has no influence on the path between take-off and touchdown. A busy flag is high for the whole time the sprite is airborne. The horizontal coordinate is a fixed home column.

Everything runs on the system clock. A one-cycle `tick_i` pulse, produced elsewhere at the game frame rate, advances the motion by one step. Between ticks all state holds. A reset button, sampled on ticks, puts the sprite back at its home position and takes priority over all other inputs. Coordinates follow screen convention, so Y grows downward. With the default parameters the floor line is at 696, the sprite is 32 pixels tall (rest Y = 664), the apex line is 164 and the step is 10 pixels per tick.

Top module: `jump_motion_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `pos_x_o` = 503, `pos_y_o` = 664 and `busy_o` = 0.
- R2: In a cycle with `tick_i` = 0, neither the jump button nor the reset button changes `pos_y_o` or `busy_o` at the next edge.
- R3: On the ground (`busy_o` = 0), a tick with the jump button at 1, or with a stored request, sets `busy_o` to 1 and leaves `pos_y_o` at 664 for that tick.
- R4: While rising, each tick with Y > 164 subtracts 10 from Y. The first tick with Y <= 164 turns the motion into a fall and leaves Y unchanged. Y never drops to 164 - 10 or below.
- R5: While falling, each tick adds 10 to Y, with Y clamped at 664. The tick that reaches 664 clears `busy_o`. `pos_y_o` is never above 664, and whenever `busy_o` = 0, `pos_y_o` = 664.
- R6: Once airborne, the level of the jump button on later ticks does not change the Y sequence until touchdown.
- R7: The jump request register is set by any tick with the jump button at 1. It is cleared only on a landing tick with the button at 0. If the button is still at 1 on the landing tick, a new jump starts on the next tick.
- R8: A press made during the fall and released before the landing tick does not start another jump.
- R9: A tick with the reset button at 1 overrides the jump button and every phase. It leaves Y = 664 and `busy_o` = 0, and clears the stored request.
- R10: `pos_x_o` stays 503 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle game-step enable |
| reset_btn_i | input | 1 | Return-to-home button, sampled on ticks |
| jump_btn_i | input | 1 | Jump button, sampled on ticks |
| pos_x_o | output | 11 | Sprite X coordinate |
| pos_y_o | output | 11 | Sprite Y coordinate (top edge, grows downward) |
| busy_o | output | 1 | High while the sprite is airborne |

## Verification
If the phase register is wrong, the fault appears at `pos_y_o` on the very next tick. A sprite stuck in the rise phase keeps climbing past the apex line. A ground phase entered too early leaves Y away from 664 while `busy_o` is already low. A request register that is not cleared shows up one tick after touchdown as a spurious take-off on `busy_o`. A request register that does not hold a short tap shows up as a missing take-off. The bench sweeps tap lengths and late presses against an arithmetic trajectory model, with an off-tick cycle between ticks, so every one of these faults appears within one tick of its cause.

// File: rtl/jmp_pkg.sv
package jmp_pkg;
  typedef enum logic [1:0] {
    PH_GROUND = 2'd0,
    PH_RISE   = 2'd1,
    PH_FALL   = 2'd2
  } phase_e;
endpackage

// File: rtl/jmp_req_latch.sv
module jmp_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic home_i,
  input  logic btn_i,
  input  logic land_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hold_q <= 1'b0;
    else if (tick_i) begin
      if (home_i)         hold_q <= 1'b0;
      else if (btn_i)     hold_q <= 1'b1;
      else if (land_i)    hold_q <= 1'b0;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/jmp_phase_fsm.sv
module jmp_phase_fsm
  import jmp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   home_i,
  input  logic   go_i,
  input  logic   apex_i,
  input  logic   land_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (home_i) phase_d = PH_GROUND;
    else begin
      unique case (phase_q)
        PH_GROUND: if (go_i)   phase_d = PH_RISE;
        PH_RISE:   if (apex_i) phase_d = PH_FALL;
        PH_FALL:   if (land_i) phase_d = PH_GROUND;
        default:               phase_d = PH_GROUND;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= PH_GROUND;
    else if (tick_i) phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/jmp_y_path.sv
module jmp_y_path
  import jmp_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int REST_Y  = 664,
  parameter int APEX_Y  = 164,
  parameter int STEP    = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               home_i,
  input  phase_e             phase_i,
  output logic [COORD_W-1:0] y_o,
  output logic               apex_o,
  output logic               land_o
);
  localparam logic [COORD_W-1:0] REST_C = COORD_W'(REST_Y);
  localparam logic [COORD_W-1:0] APEX_C = COORD_W'(APEX_Y);
  localparam logic [COORD_W-1:0] STEP_C = COORD_W'(STEP);
  localparam logic [COORD_W:0]   REST_E = (COORD_W+1)'(REST_Y);

  logic [COORD_W-1:0] y_q, y_d;
  logic [COORD_W:0]   y_down;

  // widened so the landing compare cannot wrap
  assign y_down = {1'b0, y_q} + {1'b0, STEP_C};
  assign apex_o = (y_q <= APEX_C);
  assign land_o = (y_down >= REST_E);

  always_comb begin
    y_d = y_q;
    if (home_i) y_d = REST_C;
    else begin
      unique case (phase_i)
        PH_RISE: if (!apex_o) y_d = y_q - STEP_C;
        PH_FALL: y_d = land_o ? REST_C : y_down[COORD_W-1:0];
        default: y_d = y_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     y_q <= REST_C;
    else if (tick_i) y_q <= y_d;
  end

  assign y_o = y_q;
endmodule

// File: rtl/jump_motion_ctrl.sv
module jump_motion_ctrl
  import jmp_pkg::*;
#(
  parameter int COORD_W  = 11,
  parameter int FLOOR_Y  = 696,
  parameter int SPRITE_H = 32,
  parameter int APEX_Y   = 164,
  parameter int STEP     = 10,
  parameter int HOME_X   = 503
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               reset_btn_i,
  input  logic               jump_btn_i,
  output logic [COORD_W-1:0] pos_x_o,
  output logic [COORD_W-1:0] pos_y_o,
  output logic               busy_o
);
  localparam int REST_Y = FLOOR_Y - SPRITE_H;

  phase_e phase;
  logic   hold, go, apex, land_raw, land_evt;

  assign go       = jump_btn_i | hold;
  assign land_evt = (phase == PH_FALL) & land_raw;

  jmp_req_latch u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .home_i (reset_btn_i),
    .btn_i  (jump_btn_i),
    .land_i (land_evt),
    .hold_o (hold)
  );

  jmp_phase_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .home_i  (reset_btn_i),
    .go_i    (go),
    .apex_i  (apex),
    .land_i  (land_raw),
    .phase_o (phase)
  );

  jmp_y_path #(
    .COORD_W (COORD_W),
    .REST_Y  (REST_Y),
    .APEX_Y  (APEX_Y),
    .STEP    (STEP)
  ) u_y (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .home_i  (reset_btn_i),
    .phase_i (phase),
    .y_o     (pos_y_o),
    .apex_o  (apex),
    .land_o  (land_raw)
  );

  assign pos_x_o = COORD_W'(HOME_X);
  assign busy_o  = (phase != PH_GROUND);
endmodule

// File: rtl/jump_motion_chk.sv
module jump_motion_chk #(
  parameter int COORD_W = 11,
  parameter int REST_Y  = 664,
  parameter int APEX_Y  = 164,
  parameter int STEP    = 10,
  parameter int HOME_X  = 503
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               reset_btn_i,
  input logic [COORD_W-1:0] pos_x_o,
  input logic [COORD_W-1:0] pos_y_o,
  input logic               busy_o
);
  assert_hold_off_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(pos_y_o) && $stable(busy_o)));

  assert_above_apex_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(pos_y_o) + STEP > APEX_Y));

  assert_below_rest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(pos_y_o) <= REST_Y));

  assert_ground_at_rest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (int'(pos_y_o) == REST_Y));

  assert_home_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && reset_btn_i) |=> (!busy_o && int'(pos_y_o) == REST_Y));

  assert_fixed_x_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(pos_x_o) == HOME_X));
endmodule

bind jump_motion_ctrl jump_motion_chk #(
  .COORD_W (COORD_W),
  .REST_Y  (FLOOR_Y - SPRITE_H),
  .APEX_Y  (APEX_Y),
  .STEP    (STEP),
  .HOME_X  (HOME_X)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .reset_btn_i (reset_btn_i),
  .pos_x_o     (pos_x_o),
  .pos_y_o     (pos_y_o),
  .busy_o      (busy_o)
);

// File: tb/jump_motion_ctrl_test.sv
module jump_motion_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int REST  = 664;
  localparam int APEX  = 164;
  localparam int STEP  = 10;
  localparam int HOMEX = 503;
  localparam int LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, rbtn = 1'b0, jbtn = 1'b0;
  logic [10:0] px, py;
  logic        busy;

  int checks = 0, errors = 0, cycles = 0;
  int m_y = REST, m_ph = 0;
  bit m_hold = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jump_motion_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reset_btn_i(rbtn),
    .jump_btn_i(jbtn), .pos_x_o(px), .pos_y_o(py), .busy_o(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int ax, input int ay, input bit ab,
                       input int ex, input int ey, input bit eb);
    checks++;
    if (ax != ex || ay != ey || ab != eb) begin
      errors++;
      $display("FAIL %s: x=%0d y=%0d busy=%0d expected x=%0d y=%0d busy=%0d",
               tag, ax, ay, ab, ex, ey, eb);
    end
  endtask

  // arithmetic trajectory model: phase 0 ground, 1 rise, 2 fall
  task automatic model(input bit jb, input bit rb, output string tag);
    bit land;
    if (rb) begin
      tag = "R9"; m_y = REST; m_ph = 0; m_hold = 1'b0;
    end else begin
      land = (m_ph == 2) && (m_y + STEP >= REST);
      tag = (m_ph == 0) ? "R3" : (jb ? "R6" : (m_ph == 1 ? "R4" : "R5"));
      case (m_ph)
        0: if (jb || m_hold) m_ph = 1;
        1: if (m_y > APEX) m_y -= STEP; else m_ph = 2;
        default: if (land) begin m_y = REST; m_ph = 0; end else m_y += STEP;
      endcase
      if (jb) m_hold = 1'b1;
      else if (land) m_hold = 1'b0;
    end
  endtask

  // one tick, then an off-tick cycle with scrambled buttons (R2)
  task automatic step(input bit jb, input bit rb);
    string tag;
    @(negedge clk); tick = 1'b1; jbtn = jb; rbtn = rb;
    @(negedge clk); tick = 1'b0; jbtn = ~jb; rbtn = 1'b1;
    model(jb, rb, tag);
    check(tag, px, py, busy, HOMEX, m_y, m_ph != 0);
    @(negedge clk); jbtn = 1'b0; rbtn = 1'b0;
    check("R2", px, py, busy, HOMEX, m_y, m_ph != 0);
  endtask

  initial begin
    #(3*CLK_PERIOD + 2);
    check("R1", px, py, busy, HOMEX, REST, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", px, py, busy, HOMEX, REST, 1'b0);

    // tap length sweep: short taps, holds through the whole flight and past landing (R7)
    for (int d = 1; d <= 106; d += 3) begin
      step(1'b0, 1'b1);
      for (int t = 0; t < 220; t++) step(t < d, 1'b0);
    end

    // late single press at every point of one flight (R6, R8)
    for (int p = 1; p <= 104; p += 2) begin
      step(1'b0, 1'b1);
      for (int t = 0; t < 110; t++) step(t == 0 || t == p, 1'b0);
    end

    // R8: press during fall released before landing, then ground stays idle
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    for (int t = 0; t < 70; t++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    for (int t = 0; t < 40; t++) step(1'b0, 1'b0);
    check("R8", px, py, busy, HOMEX, REST, 1'b0);

    // R9: reset button mid-air with jump held, request must be cleared
    step(1'b1, 1'b0);
    for (int t = 0; t < 20; t++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R9", px, py, busy, HOMEX, REST, 1'b0);
    step(1'b0, 1'b0);
    check("R9", px, py, busy, HOMEX, REST, 1'b0);

    // R7: held through landing re-launches on the following tick
    step(1'b1, 1'b0);
    for (int t = 0; t < 101; t++) step(1'b1, 1'b0);
    check("R7", px, py, busy, HOMEX, REST, 1'b0);
    step(1'b0, 1'b0);
    check("R7", px, py, busy, HOMEX, REST, 1'b1);
    check("R10", px, 0, 1'b0, HOMEX, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule